// File: doc/BRIEF.md
# Auto-Masking Priority Interrupt Controller

This block gathers level-sensitive interrupt request lines from the rest of the chip. It presents one combined event word to a CPU over a small register bus. Every hardware source has a single mask bit and a software-trigger bit. The request a source actually makes is its input level ORed with its software-trigger bit, and the request counts only while the source is unmasked. A separate group of fast timer sources outranks all hardware sources. These sources have mask bits but no software trigger, and they drive their own CPU output.

Software services an interrupt by reading the event register. That one read returns the winning source and sets the mask bit of that source in the same clock edge, so no acknowledge write is needed. The source stays quiet until software writes its bit to the mask-clear register. Mask and trigger bits change only through write-one-to-set and write-one-to-clear registers, so a read-modify-write sequence is never needed.

Top module: `automask_intc`

## Requirements
- R1: After reset every hardware and fast mask bit reads 1, every software-trigger bit reads 0, an event read returns 0 even while inputs are high, and both CPU outputs are low.
- R2: A hardware input counts as pending only while it is high. When the line drops, the request disappears without any software action.
- R3: Writing to offset 0x00 sets the hardware mask bits where the data has ones, and writing to offset 0x04 clears them. Zero bits in the data leave the mask unchanged. A read of offset 0x00 returns the mask.
- R4: Writing to offset 0x08 sets software-trigger bits and writing to offset 0x0C clears them, with the same write-one semantics. A read of offset 0x08 returns them. A set trigger bit requests its source exactly as a high input does, and a claim leaves the trigger bit untouched.
- R5: When several unmasked hardware requests are pending, the event names the lowest-numbered one.
- R6: The event word read at offset 0x20 has bit 31 = 1 when an event is valid, bits [17:16] = type (0 = hardware, 1 = fast timer) and bits [15:0] = source number. With nothing pending it reads all zero.
- R7: An event read that returns a valid event sets the mask bit of that source at the same clock edge. The next read then returns the next pending source.
- R8: Any unmasked fast timer request beats every hardware request, and among fast timers the lower index wins. Fast mask bits are set at offset 0x10 and cleared at offset 0x14, are read at 0x10, and are claimed like hardware masks.
- R9: `cpu_irq` is high exactly while some unmasked hardware request exists, and `cpu_fiq` is high exactly while some unmasked fast request exists. Both follow the inputs within the same cycle and fall in the cycle after the last such source is claimed.
- R10: Read data appears on `bus_rdata` in the cycle after the read is issued and holds until the next read. An event read with nothing pending changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_in | input | NUM_HW | Level hardware request lines |
| fast_irq_in | input | NUM_FAST | Level fast timer request lines |
| bus_sel | input | 1 | Bus transaction this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Unmasked hardware request present |
| cpu_fiq | output | 1 | Unmasked fast request present |

## Verification
The bench first goes after the priority order. It applies patterns whose lowest set bit sits at the bottom, the middle and the top of the hardware range, and patterns that mix fast and hardware requests. An encoder that scanned from the wrong end would name a higher source, and one that let hardware win would leave a timer unserved. Back-to-back event reads then show whether a claim really masks the source. Without the auto-mask, the same number would return twice and `cpu_irq` would never fall. Further tests look for a software trigger that a claim wrongly clears, a zero write that disturbs the masks, an empty event read that masks some source, and a lowered hardware line that stays latched as pending.

// File: rtl/amic_pkg.sv
package amic_pkg;

   localparam int EV_W     = 32;
   localparam int OFS_HMSET = 'h00;
   localparam int OFS_HMCLR = 'h04;
   localparam int OFS_SWSET = 'h08;
   localparam int OFS_SWCLR = 'h0C;
   localparam int OFS_FMSET = 'h10;
   localparam int OFS_FMCLR = 'h14;
   localparam int OFS_EVENT = 'h20;

   typedef enum logic [1:0] {
      EV_HW   = 2'd0,
      EV_FAST = 2'd1
   } ev_type_e;

   typedef struct packed {
      logic hm_set;
      logic hm_clr;
      logic sw_set;
      logic sw_clr;
      logic fm_set;
      logic fm_clr;
      logic ev_rd;
      logic rd;
   } strobe_t;

   function automatic logic [EV_W-1:0] pack_event(input logic vld,
                                                  input ev_type_e kind,
                                                  input logic [15:0] num);
      logic [EV_W-1:0] w;
      w        = '0;
      w[31]    = vld;
      w[17:16] = kind;
      w[15:0]  = num;
      return vld ? w : '0;
   endfunction

endpackage

// File: rtl/amic_lsb_pick.sv
module amic_lsb_pick #(
   parameter int N    = 32,
   parameter bit TREE = 1'b1,
   localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (N < 1) begin : g_bad_n
      $error("amic_lsb_pick: N must be at least 1");
   end

   if (TREE && N > 1) begin : g_tree
      localparam int LV = $clog2(N);
      localparam int P  = 1 << LV;
      logic          node_v [2*P-1];
      logic [LV-1:0] node_i [2*P-1];

      for (genvar k = 0; k < P; k++) begin : g_leaf
         if (k < N) begin : g_real
            assign node_v[P-1+k] = req[k];
         end else begin : g_pad
            assign node_v[P-1+k] = 1'b0;
         end
         assign node_i[P-1+k] = LV'(k);
      end

      for (genvar n = 0; n < P-1; n++) begin : g_node
         assign node_v[n] = node_v[2*n+1] | node_v[2*n+2];
         assign node_i[n] = node_v[2*n+1] ? node_i[2*n+1] : node_i[2*n+2];
      end

      assign any = node_v[0];
      assign idx = node_i[0];
   end else begin : g_linear
      always_comb begin
         idx = '0;
         for (int i = N-1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
      assign any = |req;
   end

endmodule

// File: rtl/amic_src_bank.sv
module amic_src_bank #(
   parameter int N       = 32,
   parameter bit HAS_SWT = 1'b1,
   localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  lvl_in,
   input  logic          mset_we,
   input  logic          mclr_we,
   input  logic          sset_we,
   input  logic          sclr_we,
   input  logic [N-1:0]  wbits,
   input  logic          claim_we,
   input  logic [IW-1:0] claim_idx,
   output logic [N-1:0]  mask_o,
   output logic [N-1:0]  swt_o,
   output logic [N-1:0]  pend_o
);

   logic [N-1:0] mask_q, mask_d;
   logic [N-1:0] swt_q;
   logic [N-1:0] claim_vec;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         claim_vec[i] = claim_we && (claim_idx == IW'(i));
      end
   end

   always_comb begin
      mask_d = mask_q;
      if (mset_we) mask_d = mask_d | wbits;
      if (mclr_we) mask_d = mask_d & ~wbits;
      mask_d = mask_d | claim_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '1;
      else        mask_q <= mask_d;
   end

   if (HAS_SWT) begin : g_swt
      logic [N-1:0] swt_d;
      always_comb begin
         swt_d = swt_q;
         if (sset_we) swt_d = swt_d | wbits;
         if (sclr_we) swt_d = swt_d & ~wbits;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) swt_q <= '0;
         else        swt_q <= swt_d;
      end

      a_r4_swt_set : assert property (@(posedge clk) disable iff (!rst_n)
         sset_we |=> ((swt_q & $past(wbits)) == $past(wbits)));
      a_r4_claim_keeps_swt : assert property (@(posedge clk) disable iff (!rst_n)
         (claim_we && !sset_we && !sclr_we) |=> (swt_q == $past(swt_q)));
   end else begin : g_noswt
      logic unused_swt;
      assign unused_swt = sset_we ^ sclr_we;
      assign swt_q = '0;
   end

   assign mask_o = mask_q;
   assign swt_o  = swt_q;
   assign pend_o = (lvl_in | swt_q) & ~mask_q;

   a_r7_claim_masks : assert property (@(posedge clk) disable iff (!rst_n)
      claim_we |=> mask_q[$past(claim_idx)]);
   a_r3_set_masks : assert property (@(posedge clk) disable iff (!rst_n)
      mset_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
   a_r3_clr_unmasks : assert property (@(posedge clk) disable iff (!rst_n)
      (mclr_we && !claim_we) |=> ((mask_q & $past(wbits)) == '0));
   a_r3_quiet_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!mset_we && !mclr_we && !claim_we) |=> $stable(mask_q));

endmodule

// File: rtl/amic_bus_dec.sv
module amic_bus_dec
   import amic_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output strobe_t           stb
);

   if (ADDR_W < 6) begin : g_bad_aw
      $error("amic_bus_dec: ADDR_W too small for the register map");
   end

   logic wr, rd;
   assign wr = bus_sel && bus_wr;
   assign rd = bus_sel && !bus_wr;

   always_comb begin
      stb        = '0;
      stb.rd     = rd;
      stb.hm_set = wr && (bus_addr == ADDR_W'(OFS_HMSET));
      stb.hm_clr = wr && (bus_addr == ADDR_W'(OFS_HMCLR));
      stb.sw_set = wr && (bus_addr == ADDR_W'(OFS_SWSET));
      stb.sw_clr = wr && (bus_addr == ADDR_W'(OFS_SWCLR));
      stb.fm_set = wr && (bus_addr == ADDR_W'(OFS_FMSET));
      stb.fm_clr = wr && (bus_addr == ADDR_W'(OFS_FMCLR));
      stb.ev_rd  = rd && (bus_addr == ADDR_W'(OFS_EVENT));
   end

endmodule

// File: rtl/automask_intc.sv
module automask_intc
   import amic_pkg::*;
#(
   parameter int NUM_HW   = 32,
   parameter int NUM_FAST = 4,
   parameter int ADDR_W   = 8,
   parameter bit TREE_ENC = 1'b1,
   localparam int DW      = 32,
   localparam int HIW     = (NUM_HW > 1) ? $clog2(NUM_HW) : 1,
   localparam int FIW     = (NUM_FAST > 1) ? $clog2(NUM_FAST) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_HW-1:0]   hw_irq_in,
   input  logic [NUM_FAST-1:0] fast_irq_in,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   output logic                cpu_irq,
   output logic                cpu_fiq
);

   if (NUM_HW < 1 || NUM_HW > DW) begin : g_bad_hw
      $error("automask_intc: NUM_HW must be 1..32");
   end
   if (NUM_FAST < 1 || NUM_FAST > DW) begin : g_bad_fast
      $error("automask_intc: NUM_FAST must be 1..32");
   end

   strobe_t stb;

   amic_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .stb     (stb)
   );

   logic [NUM_HW-1:0]   hw_mask, hw_swt, hw_pend;
   logic [NUM_FAST-1:0] f_mask, f_swt, f_pend;
   logic                hw_any, f_any;
   logic [HIW-1:0]      hw_idx;
   logic [FIW-1:0]      f_idx;
   logic                hw_claim, f_claim;

   assign f_claim  = stb.ev_rd && f_any;
   assign hw_claim = stb.ev_rd && !f_any && hw_any;

   amic_src_bank #(.N(NUM_HW), .HAS_SWT(1'b1)) u_hw (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (hw_irq_in),
      .mset_we  (stb.hm_set),
      .mclr_we  (stb.hm_clr),
      .sset_we  (stb.sw_set),
      .sclr_we  (stb.sw_clr),
      .wbits    (bus_wdata[NUM_HW-1:0]),
      .claim_we (hw_claim),
      .claim_idx(hw_idx),
      .mask_o   (hw_mask),
      .swt_o    (hw_swt),
      .pend_o   (hw_pend)
   );

   amic_src_bank #(.N(NUM_FAST), .HAS_SWT(1'b0)) u_fast (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (fast_irq_in),
      .mset_we  (stb.fm_set),
      .mclr_we  (stb.fm_clr),
      .sset_we  (1'b0),
      .sclr_we  (1'b0),
      .wbits    (bus_wdata[NUM_FAST-1:0]),
      .claim_we (f_claim),
      .claim_idx(f_idx),
      .mask_o   (f_mask),
      .swt_o    (f_swt),
      .pend_o   (f_pend)
   );

   amic_lsb_pick #(.N(NUM_HW), .TREE(TREE_ENC)) u_hw_pick (
      .req(hw_pend),
      .any(hw_any),
      .idx(hw_idx)
   );

   amic_lsb_pick #(.N(NUM_FAST), .TREE(TREE_ENC)) u_f_pick (
      .req(f_pend),
      .any(f_any),
      .idx(f_idx)
   );

   logic [DW-1:0] ev_word;
   always_comb begin
      if (f_any)       ev_word = pack_event(1'b1, EV_FAST, 16'(f_idx));
      else if (hw_any) ev_word = pack_event(1'b1, EV_HW, 16'(hw_idx));
      else             ev_word = '0;
   end

   logic [DW-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFS_HMSET))      rd_mux = DW'(hw_mask);
      else if (bus_addr == ADDR_W'(OFS_SWSET)) rd_mux = DW'(hw_swt);
      else if (bus_addr == ADDR_W'(OFS_FMSET)) rd_mux = DW'(f_mask);
      else if (bus_addr == ADDR_W'(OFS_EVENT)) rd_mux = ev_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (stb.rd) bus_rdata <= rd_mux;
   end

   assign cpu_irq = hw_any;
   assign cpu_fiq = f_any;

   logic unused_ok;
   assign unused_ok = ^{bus_wdata, f_swt};

   a_r5_lowest_wins : assert property (@(posedge clk) disable iff (!rst_n)
      hw_any |-> (hw_pend[hw_idx] &&
                  ((hw_pend & ((NUM_HW'(1) << hw_idx) - NUM_HW'(1))) == '0)));
   a_r8_fast_first : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.ev_rd && f_any) |=> (bus_rdata[31] && bus_rdata[17:16] == EV_FAST));
   a_r6_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.ev_rd && !f_any && !hw_any) |=> (bus_rdata == '0));
   a_r10_idle_read_no_mask : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.ev_rd && !f_any && !hw_any) |=> ($stable(hw_mask) && $stable(f_mask)));
   a_r9_irq_drops : assert property (@(posedge clk) disable iff (!rst_n)
      (hw_claim && $countones(hw_pend) == 1 && !stb.sw_set) |=> !cpu_irq);
   a_r1_event_masked : assert property (@(posedge clk) disable iff (!rst_n)
      stb.ev_rd |=> (bus_rdata[31] == $past(cpu_irq || cpu_fiq)));

endmodule

// File: tb/tb_automask_intc.sv
module tb_automask_intc;

   localparam int NHW = 32;
   localparam int NF  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NHW-1:0] hw_irq_in = '0;
   logic [NF-1:0]  fast_irq_in = '0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          cpu_irq, cpu_fiq;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   automask_intc #(.NUM_HW(NHW), .NUM_FAST(NF), .ADDR_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .hw_irq_in(hw_irq_in), .fast_irq_in(fast_irq_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq)
   );

   localparam logic [7:0] A_HMSET = 8'h00, A_HMCLR = 8'h04, A_SWSET = 8'h08,
                          A_SWCLR = 8'h0C, A_FMSET = 8'h10, A_FMCLR = 8'h14,
                          A_EVENT = 8'h20;

   // {hw lines, fast lines, expected event word}
   localparam logic [67:0] VEC [8] = '{
      {32'h0000_0001, 4'b0000, 32'h8000_0000},
      {32'h0000_0100, 4'b0000, 32'h8000_0008},
      {32'h8000_0000, 4'b0000, 32'h8000_001F},
      {32'hF0F0_0000, 4'b0000, 32'h8000_0014},
      {32'h0000_0006, 4'b0000, 32'h8000_0001},
      {32'hFFFF_FFFF, 4'b1000, 32'h8001_0003},
      {32'h0000_0000, 4'b0110, 32'h8001_0001},
      {32'h0000_0000, 4'b0000, 32'h0000_0000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic unmask_all();
      bus_write(A_HMCLR, 32'hFFFF_FFFF);
      bus_write(A_FMCLR, 32'h0000_000F);
   endtask

   task automatic mask_all();
      bus_write(A_HMSET, 32'hFFFF_FFFF);
      bus_write(A_FMSET, 32'h0000_000F);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      hw_irq_in   = 32'hFFFF_FFFF;
      fast_irq_in = 4'hF;
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq low", {30'b0, cpu_irq, cpu_fiq}, 32'h0);
      bus_read(A_HMSET, rv); check("R1 hw mask", rv, 32'hFFFF_FFFF);
      bus_read(A_SWSET, rv); check("R1 swt", rv, 32'h0);
      bus_read(A_FMSET, rv); check("R1 fast mask", rv, 32'h0000_000F);
      bus_read(A_EVENT, rv); check("R1 event", rv, 32'h0);
      bus_read(A_HMSET, rv); check("R10 empty read keeps mask", rv, 32'hFFFF_FFFF);

      // Vector table: R5, R6, R8
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         hw_irq_in   = VEC[v][67:36];
         fast_irq_in = VEC[v][35:32];
         unmask_all();
         bus_read(A_EVENT, rv);
         check($sformatf("R5/R6/R8 vector %0d", v), rv, VEC[v][31:0]);
         mask_all();
      end

      // R7 claim masks and moves on
      @(negedge clk);
      hw_irq_in = 32'h0000_0024; fast_irq_in = 4'h0;
      unmask_all();
      bus_read(A_EVENT, rv); check("R7 first claim", rv, 32'h8000_0002);
      bus_read(A_EVENT, rv); check("R7 second claim", rv, 32'h8000_0005);
      bus_read(A_EVENT, rv); check("R7 nothing left", rv, 32'h0);
      bus_read(A_HMSET, rv); check("R7 claimed bits masked", rv, 32'h0000_0024);

      // R9 outputs follow and drop after claim
      @(negedge clk);
      hw_irq_in = 32'h0000_0080;
      unmask_all();
      check("R9 irq high", {31'b0, cpu_irq}, 32'h1);
      bus_read(A_EVENT, rv); check("R9 event", rv, 32'h8000_0007);
      check("R9 irq dropped", {31'b0, cpu_irq}, 32'h0);

      // R2 level sensitivity
      unmask_all();
      @(negedge clk);
      hw_irq_in = 32'h0000_0200;
      @(negedge clk);
      check("R2 irq while high", {31'b0, cpu_irq}, 32'h1);
      hw_irq_in = 32'h0;
      @(negedge clk);
      check("R2 irq after drop", {31'b0, cpu_irq}, 32'h0);
      bus_read(A_EVENT, rv); check("R2 event after drop", rv, 32'h0);
      bus_read(A_HMSET, rv); check("R10 mask after empty read", rv, 32'h0);

      // R3 write-one semantics
      bus_write(A_HMSET, 32'h0000_0011);
      bus_read(A_HMSET, rv); check("R3 partial set", rv, 32'h0000_0011);
      bus_write(A_HMSET, 32'h0);
      bus_write(A_HMCLR, 32'h0);
      bus_read(A_HMSET, rv); check("R3 zero writes", rv, 32'h0000_0011);
      bus_write(A_HMCLR, 32'h0000_0001);
      bus_read(A_HMSET, rv); check("R3 partial clear", rv, 32'h0000_0010);

      // R4 software trigger
      unmask_all();
      bus_write(A_SWSET, 32'h0000_1000);
      bus_read(A_SWSET, rv); check("R4 swt set", rv, 32'h0000_1000);
      check("R4 swt raises irq", {31'b0, cpu_irq}, 32'h1);
      bus_read(A_EVENT, rv); check("R4 swt event", rv, 32'h8000_000C);
      bus_read(A_SWSET, rv); check("R4 claim keeps swt", rv, 32'h0000_1000);
      bus_write(A_HMCLR, 32'h0000_1000);
      bus_read(A_EVENT, rv); check("R4 swt re-fires", rv, 32'h8000_000C);
      bus_write(A_SWCLR, 32'h0000_1000);
      bus_write(A_HMCLR, 32'h0000_1000);
      bus_read(A_SWSET, rv); check("R4 swt clear", rv, 32'h0);
      check("R4 irq after swt clear", {31'b0, cpu_irq}, 32'h0);
      @(negedge clk);
      hw_irq_in = 32'h0000_1000;
      bus_write(A_SWSET, 32'h0000_1000);
      bus_write(A_SWCLR, 32'h0000_1000);
      bus_read(A_EVENT, rv); check("R4 hw alone still requests", rv, 32'h8000_000C);
      hw_irq_in = 32'h0;

      // R8 fast masks and R9 fiq
      mask_all();
      @(negedge clk);
      fast_irq_in = 4'hF;
      @(negedge clk);
      check("R8 fiq masked", {31'b0, cpu_fiq}, 32'h0);
      bus_write(A_FMCLR, 32'h0000_0004);
      check("R9 fiq high", {31'b0, cpu_fiq}, 32'h1);
      bus_read(A_EVENT, rv); check("R8 fast event", rv, 32'h8001_0002);
      check("R9 fiq dropped", {31'b0, cpu_fiq}, 32'h0);
      bus_read(A_FMSET, rv); check("R8 fast mask readback", rv, 32'h0000_000F);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule